// File: doc/BRIEF.md
# Flash Sector Address Generator

This block sits in a NAND-style flash controller and turns the values software leaves in the start-address and start-buffer registers into the operands that a load, program, copy or erase sequencer needs. It holds eight 16-bit start-address registers and one start-buffer register. All of them are written and read over a small register bus. From these registers it continuously presents the following values:

- a 512-byte sector index for the source location;
- a second sector index for the destination location;
- the transfer length in sectors;
- the buffer that the transfer targets, with its byte offset in both the main area (512-byte units) and the spare area (16-byte units);
- the first sector and sector count of a whole-block erase.

A sector index is built from a block register and a page register. With the default geometry, a page holds four sectors and a block holds 64 pages. Bit 15 of a block register selects the upper die: it ORs a per-part density mask into the block number. The sequencer samples the outputs whenever it starts a command. None of the outputs has a handshake, because they are plain level signals that follow the registers one clock after a write.

Top module: `flash_sector_addr_gen`

## Requirements
- R1: After reset, all eight address registers and the start-buffer register read 0, the transfer count is 1 and every sector and offset output is 0.
- R2: A write with `reg_addr` 0 to 7 stores the full 16-bit word in address register 0 to 7, and a read at the same index returns it.
- R3: `src_sector` equals the source page register (register 7) bits 7:0, placed below the block number taken from register 0. The page register's bits 1:0 give the sector in the page, its bits 7:2 give the page in the block, and its bits 15:8 are ignored.
- R4: `dst_sector` is formed the same way from block register 2 and page register 3.
- R5: The block number is the block register's bits 11:0. When bit 15 is set, the parameter DENSITY_MASK is ORed into it. Bits 14:12 have no effect.
- R6: A write to `reg_addr` 8 stores bits 11:8 as the buffer address and bits 1:0 as the sector count, where 0 encodes a count of 4. Bits 15:12 and 7:2 are ignored, and `xfer_count` always lies in 1 to 4.
- R7: A read of `reg_addr` 8 returns the buffer address in bits 11:8, and in bit 1 it returns bit 1 of (count − 1). All other bits read 0.
- R8: Buffer address bit 3 set selects a data buffer (`buf_is_data`=1), and bit 2 then picks data buffer 0 or 1 (`buf_data_idx`). When bit 3 is clear, the boot buffer is selected and `buf_data_idx` is 0.
- R9: `main_byte_off` is buffer address bits 1:0 times 512, and `spare_byte_off` is the same bits times 16.
- R10: `erase_first` is the source block number times 256, so its low 8 bits are 0 and its upper bits match those of `src_sector`. `erase_count` is 256.
- R11: Writes to `reg_addr` 9 to 15 change no register, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index: 0-7 address registers, 8 start buffer |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| src_sector | output | 20 | Source sector index |
| dst_sector | output | 20 | Destination sector index |
| xfer_count | output | 3 | Sectors to transfer, 1 to 4 |
| buf_is_data | output | 1 | 1 = data buffer, 0 = boot buffer |
| buf_data_idx | output | 1 | Which data buffer |
| main_byte_off | output | 11 | Main-area byte offset in the buffer |
| spare_byte_off | output | 6 | Spare-area byte offset in the buffer |
| erase_first | output | 20 | First sector of a block erase |
| erase_count | output | 9 | Sectors in a block erase |

## Verification
The bench builds the block with DENSITY_MASK set to 12'h400, a two-die part. Because of that mask, vectors with bit 15 set reach the upper-die OR path. Those vectors include the cases where the mask bit is already present and where it is newly added. The other geometry parameters stay at their defaults, so the count encoding of 0 meaning four and the bit-1 readback quirk are both exercised for every count value.

// File: rtl/flash_sag_pkg.sv
package flash_sag_pkg;
  localparam int unsigned REG_SRC_BLK  = 0;
  localparam int unsigned REG_DST_BLK  = 2;
  localparam int unsigned REG_DST_PG   = 3;
  localparam int unsigned REG_SRC_PG   = 7;
  localparam int unsigned REG_STARTBUF = 8;

  localparam int unsigned MAIN_UNIT_LOG  = 9;
  localparam int unsigned SPARE_UNIT_LOG = 4;

  typedef struct packed {
    logic       data_sel;
    logic       data_idx;
    logic [1:0] sec_off;
  } bufaddr_t;
endpackage

// File: rtl/flash_sag_regs.sv
module flash_sag_regs
  import flash_sag_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_ADDR = 8,
  parameter int unsigned SIP_W    = 2,
  parameter int unsigned RADDR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [RADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_ADDR*DATA_W-1:0] addr_flat,
  output bufaddr_t                   bufaddr,
  output logic [SIP_W:0]             count
);
  localparam int unsigned BA_LSB = 8;
  localparam int unsigned BA_W   = $bits(bufaddr_t);

  logic [DATA_W-1:0] areg_q [NUM_ADDR];
  bufaddr_t          ba_q;
  logic [SIP_W:0]    cnt_q;
  logic [SIP_W:0]    cnt_m1;

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_areg
    always_ff @(posedge clk) begin
      if (!rst_n)
        areg_q[i] <= '0;
      else if (wr && addr == RADDR_W'(i))
        areg_q[i] <= wdata;
    end
    assign addr_flat[i*DATA_W +: DATA_W] = areg_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ba_q  <= '0;
      cnt_q <= (SIP_W+1)'(1);
    end else if (wr && addr == RADDR_W'(REG_STARTBUF)) begin
      ba_q  <= wdata[BA_LSB +: BA_W];
      cnt_q <= (wdata[SIP_W-1:0] == '0) ? (SIP_W+1)'(1 << SIP_W)
                                        : {1'b0, wdata[SIP_W-1:0]};
    end
  end

  assign cnt_m1 = cnt_q - (SIP_W+1)'(1);

  always_comb begin
    rdata = '0;
    if (addr < RADDR_W'(NUM_ADDR)) begin
      rdata = areg_q[addr[$clog2(NUM_ADDR)-1:0]];
    end else if (addr == RADDR_W'(REG_STARTBUF)) begin
      rdata[BA_LSB +: BA_W] = ba_q;
      rdata[SIP_W-1]        = cnt_m1[SIP_W-1];
    end
  end

  assign bufaddr = ba_q;
  assign count   = cnt_q;

  p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= (SIP_W+1)'(1)) && (count <= (SIP_W+1)'(1 << SIP_W)));

  p_sb_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RADDR_W'(REG_STARTBUF)) |=> (bufaddr == $past(wdata[BA_LSB +: BA_W])));

  p_areg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RADDR_W'(REG_SRC_PG)) |=>
      (addr_flat[REG_SRC_PG*DATA_W +: DATA_W] == $past(wdata)));

  p_unmapped_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr > RADDR_W'(REG_STARTBUF)) |=>
      ($stable(addr_flat) && $stable(bufaddr) && $stable(count)));
endmodule

// File: rtl/flash_sag_sector.sv
module flash_sag_sector #(
  parameter int unsigned        DATA_W       = 16,
  parameter int unsigned        BLK_W        = 12,
  parameter int unsigned        PGF_W        = 8,
  parameter logic [BLK_W-1:0]   DENSITY_MASK = '0
) (
  input  logic [DATA_W-1:0]      blk_reg,
  input  logic [DATA_W-1:0]      pg_reg,
  output logic [BLK_W-1:0]       blk_num,
  output logic [BLK_W+PGF_W-1:0] sector
);
  always_comb begin
    blk_num = blk_reg[BLK_W-1:0];
    if (blk_reg[DATA_W-1])
      blk_num = blk_num | DENSITY_MASK;
  end

  assign sector = {blk_num, pg_reg[PGF_W-1:0]};
endmodule

// File: rtl/flash_sag_bufmap.sv
module flash_sag_bufmap
  import flash_sag_pkg::*;
#(
  parameter int unsigned SIP_W = 2
) (
  input  bufaddr_t                         bufaddr,
  output logic                             is_data,
  output logic                             data_idx,
  output logic [SIP_W+MAIN_UNIT_LOG-1:0]   main_off,
  output logic [SIP_W+SPARE_UNIT_LOG-1:0]  spare_off
);
  assign is_data   = bufaddr.data_sel;
  assign data_idx  = bufaddr.data_sel & bufaddr.data_idx;
  assign main_off  = {bufaddr.sec_off[SIP_W-1:0], {MAIN_UNIT_LOG{1'b0}}};
  assign spare_off = {bufaddr.sec_off[SIP_W-1:0], {SPARE_UNIT_LOG{1'b0}}};
endmodule

// File: rtl/flash_sector_addr_gen.sv
module flash_sector_addr_gen
  import flash_sag_pkg::*;
#(
  parameter int unsigned      DATA_W       = 16,
  parameter int unsigned      NUM_ADDR     = 8,
  parameter int unsigned      BLK_W        = 12,
  parameter int unsigned      PG_IDX_W     = 6,
  parameter int unsigned      SIP_W        = 2,
  parameter int unsigned      RADDR_W      = 4,
  parameter logic [BLK_W-1:0] DENSITY_MASK = '0,
  localparam int unsigned     PGF_W        = PG_IDX_W + SIP_W,
  localparam int unsigned     SEC_W        = BLK_W + PGF_W,
  localparam int unsigned     MOFF_W       = SIP_W + MAIN_UNIT_LOG,
  localparam int unsigned     SOFF_W       = SIP_W + SPARE_UNIT_LOG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [SEC_W-1:0]   src_sector,
  output logic [SEC_W-1:0]   dst_sector,
  output logic [SIP_W:0]     xfer_count,
  output logic               buf_is_data,
  output logic               buf_data_idx,
  output logic [MOFF_W-1:0]  main_byte_off,
  output logic [SOFF_W-1:0]  spare_byte_off,
  output logic [SEC_W-1:0]   erase_first,
  output logic [PGF_W:0]     erase_count
);
  logic [NUM_ADDR*DATA_W-1:0] addr_flat;
  bufaddr_t                   bufaddr;
  logic [SEC_W-1:0]           sec_arr [2];
  logic [BLK_W-1:0]           blk_arr [2];

  flash_sag_regs #(
    .DATA_W(DATA_W), .NUM_ADDR(NUM_ADDR), .SIP_W(SIP_W), .RADDR_W(RADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .addr_flat(addr_flat), .bufaddr(bufaddr), .count(xfer_count)
  );

  for (genvar g = 0; g < 2; g++) begin : g_sec
    localparam int unsigned BI = (g == 0) ? REG_SRC_BLK : REG_DST_BLK;
    localparam int unsigned PI = (g == 0) ? REG_SRC_PG  : REG_DST_PG;
    flash_sag_sector #(
      .DATA_W(DATA_W), .BLK_W(BLK_W), .PGF_W(PGF_W), .DENSITY_MASK(DENSITY_MASK)
    ) u_sec (
      .blk_reg(addr_flat[BI*DATA_W +: DATA_W]),
      .pg_reg (addr_flat[PI*DATA_W +: DATA_W]),
      .blk_num(blk_arr[g]),
      .sector (sec_arr[g])
    );
  end

  assign src_sector = sec_arr[0];
  assign dst_sector = sec_arr[1];

  flash_sag_bufmap #(.SIP_W(SIP_W)) u_buf (
    .bufaddr(bufaddr), .is_data(buf_is_data), .data_idx(buf_data_idx),
    .main_off(main_byte_off), .spare_off(spare_byte_off)
  );

  assign erase_first = {blk_arr[0], {PGF_W{1'b0}}};
  assign erase_count = (PGF_W+1)'(1 << PGF_W);

  p_erase_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_first[SEC_W-1:PGF_W] == src_sector[SEC_W-1:PGF_W]);

  p_boot_no_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_is_data |-> !buf_data_idx);

  p_off_ratio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    main_byte_off[MOFF_W-1:MAIN_UNIT_LOG] == spare_byte_off[SOFF_W-1:SPARE_UNIT_LOG]);
endmodule

// File: tb/test_flash_sector_addr_gen.sv
module test_flash_sector_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] DMASK = 12'h400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [19:0] src_sector, dst_sector, erase_first;
  logic [2:0]  xfer_count;
  logic        buf_is_data, buf_data_idx;
  logic [10:0] main_byte_off;
  logic [5:0]  spare_byte_off;
  logic [8:0]  erase_count;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_sector_addr_gen #(.DENSITY_MASK(DMASK)) i_flash_sector_addr_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_sector(src_sector),
    .dst_sector(dst_sector), .xfer_count(xfer_count), .buf_is_data(buf_is_data),
    .buf_data_idx(buf_data_idx), .main_byte_off(main_byte_off),
    .spare_byte_off(spare_byte_off), .erase_first(erase_first),
    .erase_count(erase_count)
  );

  // {block reg, page reg, expected sector}
  localparam logic [51:0] VEC [8] = '{
    {16'h0000, 16'h0000, 20'h00000},
    {16'h0001, 16'h0000, 20'h00100},
    {16'h0000, 16'hFF07, 20'h00007},
    {16'h0FFF, 16'h00FF, 20'hFFFFF},
    {16'h8003, 16'h0005, 20'h40305},
    {16'h7123, 16'h0042, 20'h12342},
    {16'h8400, 16'h0000, 20'h40000},
    {16'h8ABC, 16'h0080, 20'hEBC80}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 9; i++) rd_chk("R1 reg reset", 4'(i), 16'h0000);
    chk("R1 count", 32'(xfer_count), 32'd1);
    chk("R1 src", 32'(src_sector), 32'h0);
    chk("R1 dst", 32'(dst_sector), 32'h0);
    chk("R1 main off", 32'(main_byte_off), 32'h0);
    chk("R1 spare off", 32'(spare_byte_off), 32'h0);
    chk("R1 buf sel", 32'({buf_is_data, buf_data_idx}), 32'h0);

    // R3 R4 R5 R10 vector table
    for (int v = 0; v < 8; v++) begin
      wr(4'd0, VEC[v][51:36]);
      wr(4'd7, VEC[v][35:20]);
      wr(4'd2, VEC[v][51:36]);
      wr(4'd3, VEC[v][35:20]);
      chk("R3 src sector", 32'(src_sector), 32'(VEC[v][19:0]));
      chk("R4 dst sector", 32'(dst_sector), 32'(VEC[v][19:0]));
      chk("R10 erase first", 32'(erase_first), 32'(VEC[v][19:0] & 20'hFFF00));
      rd_chk("R2 readback blk", 4'd0, VEC[v][51:36]);
      rd_chk("R2 readback pg", 4'd7, VEC[v][35:20]);
    end
    chk("R10 erase count", 32'(erase_count), 32'd256);

    // R4 independence: dst from regs 2/3 only
    wr(4'd2, 16'h0010);
    wr(4'd3, 16'h0009);
    chk("R4 dst indep", 32'(dst_sector), 32'h01009);
    chk("R3 src unchanged", 32'(src_sector), 32'hEBC80);

    // R2 other registers
    wr(4'd1, 16'hA5A5);
    wr(4'd6, 16'h5A5A);
    rd_chk("R2 reg1", 4'd1, 16'hA5A5);
    rd_chk("R2 reg6", 4'd6, 16'h5A5A);

    // R6 R7 R8 R9 start buffer
    wr(4'd8, 16'h0F00);
    chk("R6 count zero->4", 32'(xfer_count), 32'd4);
    rd_chk("R7 readback F/4", 4'd8, 16'h0F02);
    chk("R8 data idx1", 32'({buf_is_data, buf_data_idx}), 32'h3);
    chk("R9 main off", 32'(main_byte_off), 32'd1536);
    chk("R9 spare off", 32'(spare_byte_off), 32'd48);

    wr(4'd8, 16'h0501);
    chk("R6 count 1", 32'(xfer_count), 32'd1);
    rd_chk("R7 readback 5/1", 4'd8, 16'h0500);
    chk("R8 boot", 32'({buf_is_data, buf_data_idx}), 32'h0);
    chk("R9 main off 1", 32'(main_byte_off), 32'd512);
    chk("R9 spare off 1", 32'(spare_byte_off), 32'd16);

    wr(4'd8, 16'hF2FE);
    chk("R6 count 2 ignored bits", 32'(xfer_count), 32'd2);
    rd_chk("R7 readback 2/2", 4'd8, 16'h0200);
    chk("R9 main off 2", 32'(main_byte_off), 32'd1024);

    wr(4'd8, 16'h0803);
    chk("R6 count 3", 32'(xfer_count), 32'd3);
    rd_chk("R7 readback 8/3", 4'd8, 16'h0802);
    chk("R8 data idx0", 32'({buf_is_data, buf_data_idx}), 32'h2);
    chk("R9 spare off 0", 32'(spare_byte_off), 32'd0);

    // R11 unmapped addresses
    for (int a = 9; a < 16; a++) wr(4'(a), 16'hFFFF);
    for (int a = 9; a < 16; a++) rd_chk("R11 unmapped read", 4'(a), 16'h0000);
    rd_chk("R11 reg1 kept", 4'd1, 16'hA5A5);
    rd_chk("R11 startbuf kept", 4'd8, 16'h0802);
    chk("R11 count kept", 32'(xfer_count), 32'd3);
    chk("R11 src kept", 32'(src_sector), 32'hEBC80);

    // R1 reset again clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 reg0 after reset", 4'd0, 16'h0000);
    chk("R1 count after reset", 32'(xfer_count), 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule